// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes one left and one right audio sample per frame and shifts them out, most significant bit first, on a single serial data line. It is paced by a bit clock and a word-select line. Two framing conventions are available. In the I2S framing, word-select low selects the left channel and the first data bit comes one bit clock after the word-select edge. In the left-aligned framing, word-select high selects the left channel and the first data bit sits in the slot that directly follows the edge. Each channel gets 32 bit slots. Slots beyond the sample width are sent as zeros.

The block can own the serial clocks or follow them. When it owns them, it divides its 256x-sample-rate system clock by four to make the bit clock, and it toggles word-select every 32 bit clocks. When it follows, it synchronises an external bit clock and word-select and counts slots from the word-select edges. All serial outputs change only on the falling edge of the bit clock.

A new sample pair can be offered at any time with a one-cycle strobe. The pair is held and moves into the shifter only at the start of the next frame. While the power-on input is low, the block stays idle. After power-on, the data line stays low for a programmable number of whole frames, so that an upstream decimator can settle.

Top module: `stereo_ser_tx`

## Requirements
- R1: When it owns the clocks, `bclk_out` has a period of 4 `clk` cycles, high for 2 and low for 2.
- R2: When it owns the clocks, `ws_out` holds one level for 32 bit clocks and the other level for the next 32. It changes only in the cycle where `bclk_out` falls.
- R3: With `fmt_msbj`=0 (I2S), the left word is sent while word-select is 0, in slots 1..24 of that half-frame, MSB first. The right word is sent in the same slots of the half-frame where word-select is 1. Slot 0 is the first bit clock after the word-select edge.
- R4: With `fmt_msbj`=1 (left-aligned), the left word is sent while word-select is 1, in slots 0..23, MSB first. The right word is sent in the same slots while word-select is 0.
- R5: When it owns the clocks, `sdata` changes only in the cycle where `bclk_out` falls.
- R6: Every slot outside the 24 data slots of each half-frame carries 0.
- R7: With `master_sel`=0, `bclk_out` and `ws_out` are 0. Framing follows `bclk_in` and `ws_in`: a word-select edge sampled at a falling bit-clock edge marks slot 0 of the channel that the new level selects.
- R8: While `pwr_on` is 0, `sdata` is 0 from the next cycle on. After `pwr_on` rises, the first MUTE_FRAMES complete frames carry only zeros, and the frame after them carries the held samples.
- R9: A pair strobed by `smp_valid` during a frame is not sent in that frame. It is sent whole in the next frame.
- R10: While `pwr_on` is 0, `bclk_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = run, 0 = power-down |
| fmt_msbj | input | 1 | Framing: 0 = I2S, 1 = left-aligned |
| master_sel | input | 1 | 0 = follow external clocks, 1 = generate clocks |
| smp_valid | input | 1 | One-cycle strobe that accepts a sample pair |
| smp_left | input | WORD_W | Left sample |
| smp_right | input | WORD_W | Right sample |
| bclk_in | input | 1 | External bit clock (follower mode) |
| ws_in | input | 1 | External word-select (follower mode) |
| bclk_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word-select |
| sdata | output | 1 | Serial data |

## Verification
The bench keeps the 24-bit word, 32-slot channel and divide-by-4 defaults. It sets MUTE_FRAMES to 3, which brings the end of the startup mute within a few hundred bit clocks. With that value the exact frame in which data first appears can be checked in both framings. In follower mode the bench drives a slow external bit clock of 12 system cycles, so the synchroniser latency stays inside the low phase. This exercises framing that is recovered from word-select edges.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic {
        FMT_I2S        = 1'b0,
        FMT_LEFT_ALIGN = 1'b1
    } fmt_e;

    // number of idle slots between the word-select edge and the MSB
    function automatic int lead_slots(input logic fmt);
        return (fmt_e'(fmt) == FMT_I2S) ? 1 : 0;
    endfunction
endpackage

// File: rtl/sertx_timing.sv
module sertx_timing #(
    parameter int BCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic master,
    input  logic bclk_in,
    input  logic ws_in,
    output logic bclk_out,
    output logic fall_evt,
    output logic ws_ext
);
    localparam int DW = $clog2(BCLK_DIV);

    typedef struct packed {
        logic [DW-1:0] div;
        logic          bclk;
        logic          bs1;
        logic          bs2;
        logic          bs3;
        logic          ws1;
        logic          ws2;
    } tim_t;

    tim_t tim_q, tim_d;

    always_comb begin
        tim_d     = tim_q;
        tim_d.bs1 = bclk_in;
        tim_d.bs2 = tim_q.bs1;
        tim_d.bs3 = tim_q.bs2;
        tim_d.ws1 = ws_in;
        tim_d.ws2 = tim_q.ws1;
        if (run && master) begin
            tim_d.div  = (tim_q.div == DW'(BCLK_DIV - 1)) ? '0 : tim_q.div + 1'b1;
            tim_d.bclk = (tim_d.div >= DW'(BCLK_DIV / 2));
        end else begin
            tim_d.div  = '0;
            tim_d.bclk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign bclk_out = tim_q.bclk;
    assign ws_ext   = tim_q.ws2;
    assign fall_evt = run && (master ? (tim_q.div == DW'(BCLK_DIV - 1))
                                     : (tim_q.bs3 && !tim_q.bs2));
endmodule

// File: rtl/sertx_mute.sv
module sertx_mute #(
    parameter int MUTE_FRAMES = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic frame_start,
    output logic mute_now
);
    localparam int CW = $clog2(MUTE_FRAMES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mute;
    } mut_t;

    mut_t mut_q, mut_d;

    always_comb begin
        mut_d = mut_q;
        if (!run) begin
            mut_d.cnt  = CW'(MUTE_FRAMES);
            mut_d.mute = 1'b1;
        end else if (frame_start) begin
            mut_d.mute = (mut_q.cnt != '0);
            if (mut_q.cnt != '0) mut_d.cnt = mut_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mut_q.cnt  <= CW'(MUTE_FRAMES);
            mut_q.mute <= 1'b1;
        end else begin
            mut_q <= mut_d;
        end
    end

    assign mute_now = !run || (frame_start ? (mut_q.cnt != '0) : mut_q.mute);
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
    parameter int WORD_W      = 24,
    parameter int SLOT_W      = 32,
    parameter int BCLK_DIV    = 4,
    parameter int MUTE_FRAMES = 12288
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              fmt_msbj,
    input  logic              master_sel,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_left,
    input  logic [WORD_W-1:0] smp_right,
    input  logic              bclk_in,
    input  logic              ws_in,
    output logic              bclk_out,
    output logic              ws_out,
    output logic              sdata
);
    import sertx_pkg::*;

    localparam int FRAME_W = 2 * SLOT_W;
    localparam int PW      = $clog2(FRAME_W);
    localparam int SW      = $clog2(SLOT_W);
    localparam int IW      = $clog2(WORD_W);

    typedef struct packed {
        logic [PW-1:0]     pos;
        logic              ws;
        logic              sd;
        logic              wslast;
        logic [WORD_W-1:0] act_l;
        logic [WORD_W-1:0] act_r;
        logic [WORD_W-1:0] pend_l;
        logic [WORD_W-1:0] pend_r;
    } tx_t;

    tx_t tx_q, tx_d;

    logic          fall_evt;
    logic          ws_ext;
    logic          mute_now;
    logic          frame_start;
    logic [PW-1:0] pos_n;

    sertx_timing #(.BCLK_DIV(BCLK_DIV)) i_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pwr_on),
        .master   (master_sel),
        .bclk_in  (bclk_in),
        .ws_in    (ws_in),
        .bclk_out (bclk_out),
        .fall_evt (fall_evt),
        .ws_ext   (ws_ext)
    );

    sertx_mute #(.MUTE_FRAMES(MUTE_FRAMES)) i_mute (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (pwr_on),
        .frame_start (frame_start),
        .mute_now    (mute_now)
    );

    // slot position that the next falling bit-clock edge moves to
    always_comb begin
        if (master_sel)                 pos_n = tx_q.pos + 1'b1;
        else if (ws_ext != tx_q.wslast) pos_n = (ws_ext == fmt_msbj) ? '0 : PW'(SLOT_W);
        else                            pos_n = tx_q.pos + 1'b1;
        frame_start = fall_evt && (pos_n == '0);
    end

    logic              right_ch;
    logic [SW-1:0]     slot;
    logic [WORD_W-1:0] word;
    logic [IW-1:0]     idx;
    logic              bit_v;
    int                k;

    always_comb begin
        tx_d = tx_q;
        if (smp_valid) begin
            tx_d.pend_l = smp_left;
            tx_d.pend_r = smp_right;
        end
        right_ch = pos_n[PW-1];
        slot     = pos_n[SW-1:0];
        k        = int'(slot) - lead_slots(fmt_msbj);
        idx      = '0;
        bit_v    = 1'b0;
        word     = '0;
        if (!pwr_on) begin
            tx_d.pos    = PW'(FRAME_W - 1);
            tx_d.ws     = master_sel && !fmt_msbj;
            tx_d.sd     = 1'b0;
            tx_d.wslast = ws_ext;
        end else if (fall_evt) begin
            tx_d.pos    = pos_n;
            tx_d.wslast = ws_ext;
            if (frame_start) begin
                tx_d.act_l = tx_q.pend_l;
                tx_d.act_r = tx_q.pend_r;
            end
            word = right_ch ? tx_d.act_r : tx_d.act_l;
            if (k >= 0 && k < WORD_W) begin
                idx   = IW'(WORD_W - 1 - k);
                bit_v = word[idx];
            end
            tx_d.ws = master_sel && (right_ch ^ fmt_msbj);
            tx_d.sd = mute_now ? 1'b0 : bit_v;
        end else if (!master_sel) begin
            tx_d.ws = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            tx_q.pos <= PW'(FRAME_W - 1);
        end else begin
            tx_q <= tx_d;
        end
    end

    assign ws_out = tx_q.ws;
    assign sdata  = tx_q.sd;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_on,
    input logic master_sel,
    input logic bclk_out,
    input logic ws_out,
    input logic sdata
);
    logic own_steady;
    assign own_steady = pwr_on && master_sel;

    AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (own_steady && $past(own_steady) && $rose(bclk_out)) |=> bclk_out); // R1

    AST_BCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (own_steady && $past(own_steady) && $fell(bclk_out)) |=> !bclk_out); // R1

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (own_steady && $past(own_steady) && !$stable(ws_out)) |-> $fell(bclk_out)); // R2

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (own_steady && $past(own_steady) && !$stable(sdata)) |-> $fell(bclk_out)); // R5

    AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |=> (!bclk_out && !ws_out)); // R7

    AST_POWERDOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !sdata); // R8

    AST_POWERDOWN_NO_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !bclk_out); // R10
endmodule

bind stereo_ser_tx sertx_checker i_sertx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_on     (pwr_on),
    .master_sel (master_sel),
    .bclk_out   (bclk_out),
    .ws_out     (ws_out),
    .sdata      (sdata)
);

// File: tb/test_stereo_ser_tx.sv
`timescale 1ns/1ps
module test_stereo_ser_tx;
    localparam int WW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_on = 1'b0;
    logic          fmt_msbj = 1'b0;
    logic          master_sel = 1'b1;
    logic          smp_valid = 1'b0;
    logic [WW-1:0] smp_left = '0;
    logic [WW-1:0] smp_right = '0;
    logic          bclk_in = 1'b1;
    logic          ws_in = 1'b1;
    logic          bclk_out, ws_out, sdata;

    int checks = 0;
    int errors = 0;
    int sl_pos = 32;
    logic pk_v = 1'b0, pk_w = 1'b0, pk_d = 1'b0;

    always #2.5 clk = ~clk;

    stereo_ser_tx #(.MUTE_FRAMES(3)) i_stereo_ser_tx (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .fmt_msbj(fmt_msbj),
        .master_sel(master_sel), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .bclk_in(bclk_in), .ws_in(ws_in),
        .bclk_out(bclk_out), .ws_out(ws_out), .sdata(sdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected frame: slot i of the frame in bit i
    function automatic logic [63:0] exp_frame(input logic [WW-1:0] l, input logic [WW-1:0] r, input logic f);
        logic [63:0] fr = '0;
        int off = f ? 0 : 1;
        for (int j = 0; j < WW; j++) begin
            fr[off + j]      = l[WW-1-j];
            fr[32 + off + j] = r[WW-1-j];
        end
        return fr;
    endfunction

    function automatic logic [63:0] exp_ws(input logic f);
        logic [63:0] w;
        for (int i = 0; i < 64; i++) w[i] = (i >= 32) ? ~f : f;
        return w;
    endfunction

    task automatic get_bit(output logic w, output logic d);
        if (pk_v) begin
            w = pk_w; d = pk_d; pk_v = 1'b0;
        end else if (master_sel) begin
            @(posedge bclk_out);
            @(negedge clk);
            w = ws_out; d = sdata;
        end else begin
            @(negedge clk);
            bclk_in = 1'b0;
            ws_in = (sl_pos >= 32) ? ~fmt_msbj : fmt_msbj;
            w = ws_in;
            repeat (6) @(negedge clk);
            bclk_in = 1'b1;
            d = sdata;
            repeat (5) @(negedge clk);
            sl_pos = (sl_pos + 1) % 64;
        end
    endtask

    task automatic align();
        logic w, d, pw;
        bit have = 1'b0;
        for (int n = 0; n < 300; n++) begin
            get_bit(w, d);
            if (have && w == fmt_msbj && pw != fmt_msbj) begin
                pk_v = 1'b1; pk_w = w; pk_d = d;
                return;
            end
            pw = w; have = 1'b1;
        end
    endtask

    task automatic give_sample(input logic [WW-1:0] l, input logic [WW-1:0] r);
        @(negedge clk);
        smp_left = l; smp_right = r; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic read_frame(output logic [63:0] fr, output logic [63:0] wv,
                              input int chg_at, input logic [WW-1:0] nl, input logic [WW-1:0] nr);
        logic w, d;
        for (int i = 0; i < 64; i++) begin
            get_bit(w, d);
            fr[i] = d; wv[i] = w;
            if (i == chg_at) give_sample(nl, nr);
        end
    endtask

    task automatic power_up(input logic ms, input logic f);
        @(negedge clk);
        pwr_on = 1'b0; master_sel = ms; fmt_msbj = f;
        bclk_in = 1'b1; ws_in = ~f; sl_pos = 32; pk_v = 1'b0;
        repeat (6) @(negedge clk);
        pwr_on = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(sdata == 1'b0, "R8 reset sdata", 64'(sdata), 64'h0);
        check(bclk_out == 1'b0, "R10 reset bclk", 64'(bclk_out), 64'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bclk_out == 1'b0 && sdata == 1'b0, "R10 power-down idle",
              {62'h0, bclk_out, sdata}, 64'h0);
    endtask

    task automatic t_master_mute();
        logic [63:0] fr, wv;
        bit z = 1'b1;
        give_sample(24'hA5C3E1, 24'h1F2E3D);
        power_up(1'b1, 1'b0);
        align();
        for (int f = 0; f < 3; f++) begin
            read_frame(fr, wv, -1, '0, '0);
            if (fr != 64'h0) z = 1'b0;
        end
        check(z, "R8 muted frames", 64'(z), 64'h1);
        read_frame(fr, wv, -1, '0, '0);
        check(fr == exp_frame(24'hA5C3E1, 24'h1F2E3D, 1'b0), "R3 first live I2S frame",
              fr, exp_frame(24'hA5C3E1, 24'h1F2E3D, 1'b0));
        check(wv == exp_ws(1'b0), "R2 ws pattern I2S", wv, exp_ws(1'b0));
        check((fr & ~exp_frame('1, '1, 1'b0)) == 64'h0, "R6 trailing slots zero",
              fr & ~exp_frame('1, '1, 1'b0), 64'h0);
    endtask

    task automatic t_bclk_shape();
        int hc, lc;
        logic sd0;
        bit stable = 1'b1;
        @(posedge bclk_out); @(negedge clk);
        hc = 0; lc = 0;
        while (bclk_out) begin hc++; @(negedge clk); end
        while (!bclk_out) begin lc++; @(negedge clk); end
        check(hc == 2, "R1 bclk high cycles", 64'(hc), 64'd2);
        check(lc == 2, "R1 bclk low cycles", 64'(lc), 64'd2);
        for (int p = 0; p < 64; p++) begin
            @(posedge bclk_out); @(negedge clk);
            sd0 = sdata;
            @(negedge clk);
            if (sdata != sd0) stable = 1'b0;
        end
        check(stable, "R5 sdata steady while bclk high", 64'(stable), 64'h1);
    endtask

    task automatic t_latch();
        logic [63:0] fr, wv;
        give_sample(24'h123456, 24'h654321);
        align();
        read_frame(fr, wv, -1, '0, '0);
        read_frame(fr, wv, 40, 24'hFEDCBA, 24'h0F0F0F);
        check(fr == exp_frame(24'h123456, 24'h654321, 1'b0), "R9 mid-frame update held",
              fr, exp_frame(24'h123456, 24'h654321, 1'b0));
        read_frame(fr, wv, -1, '0, '0);
        check(fr == exp_frame(24'hFEDCBA, 24'h0F0F0F, 1'b0), "R9 update in next frame",
              fr, exp_frame(24'hFEDCBA, 24'h0F0F0F, 1'b0));
    endtask

    task automatic t_master_leftalign();
        logic [63:0] fr, wv;
        give_sample(24'h800001, 24'h7FFFFE);
        power_up(1'b1, 1'b1);
        align();
        for (int f = 0; f < 4; f++) read_frame(fr, wv, -1, '0, '0);
        check(fr == exp_frame(24'h800001, 24'h7FFFFE, 1'b1), "R4 left-aligned frame",
              fr, exp_frame(24'h800001, 24'h7FFFFE, 1'b1));
        check(wv == exp_ws(1'b1), "R4 ws high for left", wv, exp_ws(1'b1));
    endtask

    task automatic t_powerdown();
        @(negedge clk);
        pwr_on = 1'b0;
        repeat (2) @(negedge clk);
        check(sdata == 1'b0, "R8 power-down forces sdata low", 64'(sdata), 64'h0);
        repeat (8) @(negedge clk);
        check(bclk_out == 1'b0, "R10 power-down stops bclk", 64'(bclk_out), 64'h0);
    endtask

    task automatic t_follower(input logic f, input logic [WW-1:0] l, input logic [WW-1:0] r);
        logic [63:0] fr, wv;
        give_sample(l, r);
        power_up(1'b0, f);
        align();
        for (int n = 0; n < 4; n++) read_frame(fr, wv, -1, '0, '0);
        check(fr == exp_frame(l, r, f), "R7 follower frame", fr, exp_frame(l, r, f));
        check(bclk_out == 1'b0 && ws_out == 1'b0, "R7 follower outputs idle",
              {62'h0, bclk_out, ws_out}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_master_mute();
        t_bclk_shape();
        t_latch();
        t_master_leftalign();
        t_powerdown();
        t_follower(1'b0, 24'hC0FFEE, 24'h00BEEF);
        t_follower(1'b1, 24'h5A5A5A, 24'hA0000F);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule